// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Sequencer

This block keeps a dynamic memory array alive without help from the host. Once reset is released it stays quiet for a programmable power-up pause. It then runs a wake-up burst of CAS-before-RAS cycles. After the burst it paces refresh cycles from a free-running interval timer. To reach the memory pins it asks the access controller for the bus through a request/grant pair. While one of its own cycles is in flight it drives the RAS, CAS and write strobes. A `ready` output tells the access controller when host traffic may begin.

Refresh slots that cannot be served at once, because the grant is withheld, are counted up to a fixed ceiling. They are issued later, one after another, as soon as the grant returns. The block also watches the row strobe: its own and the host's. If the row strobe stays inactive longer than the retention limit, the block withdraws `ready` and repeats the full wake-up burst. All delays are parameters counted in clock cycles.

Top module: `rfsh_seq_top`

## Requirements
- R1: After reset release, `bus_req` and `ready` stay low and both strobes stay high for exactly `PAUSE_CYC` clock cycles. `bus_req` is first seen high after the `PAUSE_CYC`-th rising edge.
- R2: After the pause, exactly `WAKE_CYCLES` (default 8) refresh cycles are issued. `ready` rises on the clock edge at which the last of them ends, and the strobe drive drops at that same edge.
- R3: Each refresh cycle has a fixed shape. First `cas_n` is low with `ras_n` high for `CSR_CYC` cycles. Then both are low for `RAS_CYC` cycles. Then both are high for `RP_CYC` cycles. `cas_n` never rises while `ras_n` is low.
- R4: `we_n` is always high. A cycle starts only after an edge at which `bus_req` and `bus_gnt` were both high. While `strobe_en` is low, `ras_n` and `cas_n` are high.
- R5: Once initialised, the interval timer adds one owed refresh every `INTERVAL_CYC` cycles. `bus_req` stays high until it is granted and the owed refreshes are paid.
- R6: The owed-refresh count saturates at `PEND_MAX` (default 8). After a long grant stall, exactly `PEND_MAX` cycles are issued back to back, with one idle clock between consecutive cycles.
- R7: Suppose both the block's `ras_n` and `host_ras_n` stay high for `IDLE_LIMIT_CYC` consecutive cycles while `ready` is high. Then `ready` drops. It returns only after a fresh burst of `WAKE_CYCLES` cycles.
- R8: Any cycle with `host_ras_n` low restarts the idle count, so host row activity keeps `ready` high through a grant stall.
- R9: Reset is asynchronous and active low. While it is asserted, `ready`, `bus_req` and `strobe_en` are low, and `ras_n` and `cas_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_gnt | input | 1 | Grant of the memory bus from the access controller |
| host_ras_n | input | 1 | Row strobe as driven by the host path, active low |
| bus_req | output | 1 | Request for the memory bus |
| strobe_en | output | 1 | High while this block owns and drives the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| ready | output | 1 | Initialisation complete; host traffic allowed |

## Verification
The properties assume that the access controller grants the bus only while this block requests it. They also assume the controller never takes the bus back in the middle of a cycle: once started, a cycle runs to its end whatever `bus_gnt` does. The stimulus changes `bus_gnt` and `host_ras_n` only between edges. It withholds the grant for long stretches to build up owed refreshes and, later, to provoke the idle timeout. It pulses `host_ras_n` during one stall so that the timeout must not fire there.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CSR   = 2'd1,
    PH_RASLO = 2'd2,
    PH_PRE   = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    M_PAUSE = 2'd0,
    M_WAKE  = 2'd1,
    M_RUN   = 2'd2
  } mode_t;

endpackage

// File: rtl/rfsh_cbr_gen.sv
module rfsh_cbr_gen
  import rfsh_pkg::*;
#(
  parameter int CSR_CYC = 1,
  parameter int RAS_CYC = 5,
  parameter int RP_CYC  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic cas_n
);

  localparam int MAX_A = (CSR_CYC > RAS_CYC) ? CSR_CYC : RAS_CYC;
  localparam int MAX_C = (MAX_A > RP_CYC) ? MAX_A : RP_CYC;
  localparam int CW    = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] CSR_LAST = CW'(CSR_CYC - 1);
  localparam logic [CW-1:0] RAS_LAST = CW'(RAS_CYC - 1);
  localparam logic [CW-1:0] RP_LAST  = CW'(RP_CYC - 1);

  phase_t        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d  = PH_CSR;
          cnt_d = '0;
        end
      end
      PH_CSR: begin
        if (cnt_q == CSR_LAST) begin
          ph_d  = PH_RASLO;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      PH_RASLO: begin
        if (cnt_q == RAS_LAST) begin
          ph_d  = PH_PRE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      PH_PRE: begin
        if (cnt_q == RP_LAST) begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy  = (ph_q != PH_IDLE);
  assign done  = (ph_q == PH_PRE) && (cnt_q == RP_LAST);
  assign ras_n = (ph_q != PH_RASLO);
  assign cas_n = !((ph_q == PH_CSR) || (ph_q == PH_RASLO));

endmodule

// File: rtl/rfsh_pace.sv
module rfsh_pace #(
  parameter int INTERVAL_CYC = 1560,
  parameter int PEND_MAX     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic done,
  output logic pend_nz
);

  localparam int TW = $clog2(INTERVAL_CYC + 1);
  localparam int PW = $clog2(PEND_MAX + 1);
  localparam logic [TW-1:0] T_LAST = TW'(INTERVAL_CYC - 1);
  localparam logic [PW-1:0] P_TOP  = PW'(PEND_MAX);

  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [PW-1:0] pend_q, pend_d;
  logic          tick;

  always_comb begin
    tick   = en && (tcnt_q == T_LAST);
    tcnt_d = tcnt_q;
    if (!en || tick) begin
      tcnt_d = '0;
    end else begin
      tcnt_d = tcnt_q + TW'(1);
    end

    pend_d = pend_q;
    if (tick && !done) begin
      if (pend_q != P_TOP) begin
        pend_d = pend_q + PW'(1);
      end
    end else if (done && !tick) begin
      if (pend_q != '0) begin
        pend_d = pend_q - PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      pend_q <= '0;
    end else begin
      tcnt_q <= tcnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend_nz = (pend_q != '0);

endmodule

// File: rtl/rfsh_idle_mon.sv
module rfsh_idle_mon #(
  parameter int IDLE_LIMIT_CYC = 1640000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ras_high,
  output logic hit
);

  localparam int IW = $clog2(IDLE_LIMIT_CYC + 1);
  localparam logic [IW-1:0] I_LAST = IW'(IDLE_LIMIT_CYC - 1);

  logic [IW-1:0] icnt_q, icnt_d;

  always_comb begin
    hit    = en && ras_high && (icnt_q == I_LAST);
    icnt_d = icnt_q;
    if (!en || !ras_high || hit) begin
      icnt_d = '0;
    end else begin
      icnt_d = icnt_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt_q <= '0;
    end else begin
      icnt_q <= icnt_d;
    end
  end

endmodule

// File: rtl/rfsh_seq_top.sv
module rfsh_seq_top
  import rfsh_pkg::*;
#(
  parameter int PAUSE_CYC      = 50000,
  parameter int WAKE_CYCLES    = 8,
  parameter int INTERVAL_CYC   = 1560,
  parameter int IDLE_LIMIT_CYC = 1640000,
  parameter int PEND_MAX       = 8,
  parameter int CSR_CYC        = 1,
  parameter int RAS_CYC        = 5,
  parameter int RP_CYC         = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_gnt,
  input  logic host_ras_n,
  output logic bus_req,
  output logic strobe_en,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic ready
);

  localparam int PCW = $clog2(PAUSE_CYC + 1);
  localparam int WW  = $clog2(WAKE_CYCLES + 1);
  localparam logic [PCW-1:0] P_LAST = PCW'(PAUSE_CYC - 1);
  localparam logic [WW-1:0]  W_INIT = WW'(WAKE_CYCLES);

  mode_t          mode_q, mode_d;
  logic [PCW-1:0] pcnt_q, pcnt_d;
  logic [WW-1:0]  wleft_q, wleft_d;

  logic cyc_busy, cyc_done, cyc_ras_n, cyc_cas_n;
  logic pend_nz, idle_hit, want, start;

  assign want  = (mode_q == M_WAKE) || ((mode_q == M_RUN) && pend_nz);
  assign start = want && bus_gnt && !cyc_busy;

  rfsh_cbr_gen #(
    .CSR_CYC (CSR_CYC),
    .RAS_CYC (RAS_CYC),
    .RP_CYC  (RP_CYC)
  ) u_gen (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (cyc_busy),
    .done  (cyc_done),
    .ras_n (cyc_ras_n),
    .cas_n (cyc_cas_n)
  );

  rfsh_pace #(
    .INTERVAL_CYC (INTERVAL_CYC),
    .PEND_MAX     (PEND_MAX)
  ) u_pace (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (mode_q != M_PAUSE),
    .done    (cyc_done),
    .pend_nz (pend_nz)
  );

  rfsh_idle_mon #(
    .IDLE_LIMIT_CYC (IDLE_LIMIT_CYC)
  ) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (mode_q == M_RUN),
    .ras_high (host_ras_n && cyc_ras_n),
    .hit      (idle_hit)
  );

  always_comb begin
    mode_d  = mode_q;
    pcnt_d  = pcnt_q;
    wleft_d = wleft_q;
    case (mode_q)
      M_PAUSE: begin
        if (pcnt_q == P_LAST) begin
          mode_d  = M_WAKE;
          wleft_d = W_INIT;
        end else begin
          pcnt_d = pcnt_q + PCW'(1);
        end
      end
      M_WAKE: begin
        if (cyc_done) begin
          if (wleft_q == WW'(1)) begin
            mode_d = M_RUN;
          end else begin
            wleft_d = wleft_q - WW'(1);
          end
        end
      end
      M_RUN: begin
        if (idle_hit) begin
          mode_d  = M_WAKE;
          wleft_d = W_INIT;
        end
      end
      default: begin
        mode_d = M_PAUSE;
        pcnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_PAUSE;
      pcnt_q  <= '0;
      wleft_q <= W_INIT;
    end else begin
      mode_q  <= mode_d;
      pcnt_q  <= pcnt_d;
      wleft_q <= wleft_d;
    end
  end

  assign bus_req   = cyc_busy || want;
  assign strobe_en = cyc_busy;
  assign ras_n     = cyc_ras_n;
  assign cas_n     = cyc_cas_n;
  assign we_n      = 1'b1;
  assign ready     = (mode_q == M_RUN);

endmodule

// File: rtl/rfsh_seq_chk.sv
module rfsh_seq_chk #(
  parameter int RAS_CYC = 5
) (
  input logic clk,
  input logic rst_n,
  input logic bus_req,
  input logic bus_gnt,
  input logic strobe_en,
  input logic ras_n,
  input logic cas_n,
  input logic ready
);

  localparam int CW = $clog2(RAS_CYC + 2);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (!ras_n) begin
      low_cnt <= low_cnt + CW'(1);
    end else begin
      low_cnt <= '0;
    end
  end

  assert_cas_leads_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));

  assert_cas_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);

  assert_ras_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (low_cnt == CW'(RAS_CYC)));

  assert_idle_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_en |-> (ras_n && cas_n));

  assert_start_granted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_en) |-> $past(bus_gnt && bus_req));

  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !strobe_en) |=> bus_req);

  assert_ready_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $fell(strobe_en));

endmodule

bind rfsh_seq_top rfsh_seq_chk #(
  .RAS_CYC (RAS_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .strobe_en (strobe_en),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .ready     (ready)
);

// File: tb/tb_rfsh_seq_top.sv
module tb_rfsh_seq_top;

  localparam int CLK_PERIOD = 10;
  localparam int PAUSE  = 20;
  localparam int WAKE   = 8;
  localparam int INTV   = 30;
  localparam int IDLE   = 60;
  localparam int PMAX   = 8;
  localparam int CSR    = 1;
  localparam int RASC   = 3;
  localparam int RP     = 2;
  localparam int CYCLEN = CSR + RASC + RP;
  localparam int WD_CYC = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic bus_gnt = 1'b0;
  logic host_ras_n = 1'b1;
  logic bus_req, strobe_en, ras_n, cas_n, we_n, ready;

  rfsh_seq_top #(
    .PAUSE_CYC (PAUSE), .WAKE_CYCLES (WAKE), .INTERVAL_CYC (INTV),
    .IDLE_LIMIT_CYC (IDLE), .PEND_MAX (PMAX),
    .CSR_CYC (CSR), .RAS_CYC (RASC), .RP_CYC (RP)
  ) dut (
    .clk (clk), .rst_n (rst_n), .bus_gnt (bus_gnt), .host_ras_n (host_ras_n),
    .bus_req (bus_req), .strobe_en (strobe_en), .ras_n (ras_n),
    .cas_n (cas_n), .we_n (we_n), .ready (ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vec_cnt = 0;
  int err_cnt = 0;
  int fall_cnt = 0;
  bit prev_ras = 1'b1;

  // behavioural reference model
  int m_mode = 0;
  int m_pcnt = 0;
  int m_wleft = WAKE;
  int m_pend = 0;
  int m_tcnt = 0;
  int m_idle = 0;
  int m_busy = 0;
  int m_pos = 0;

  function automatic bit m_ras_n();
    return !(m_busy != 0 && m_pos >= CSR && m_pos < CSR + RASC);
  endfunction
  function automatic bit m_cas_n();
    return !(m_busy != 0 && m_pos < CSR + RASC);
  endfunction
  function automatic bit m_want();
    return (m_mode == 1) || (m_mode == 2 && m_pend > 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_pcnt = 0; m_wleft = WAKE; m_pend = 0;
      m_tcnt = 0; m_idle = 0; m_busy = 0; m_pos = 0;
    end else begin
      bit done, start, tick, rhigh, hit;
      int np;
      done  = (m_busy != 0) && (m_pos == CYCLEN - 1);
      start = (m_busy == 0) && m_want() && bus_gnt;
      tick  = (m_mode != 0) && (m_tcnt == INTV - 1);
      rhigh = host_ras_n && m_ras_n();
      hit   = (m_mode == 2) && rhigh && (m_idle == IDLE - 1);
      np = m_pend + int'(tick) - int'(done);
      if (np > PMAX) np = PMAX;
      if (np < 0) np = 0;
      m_pend = np;
      m_tcnt = (m_mode == 0 || tick) ? 0 : m_tcnt + 1;
      m_idle = (m_mode != 2 || !rhigh || hit) ? 0 : m_idle + 1;
      case (m_mode)
        0: if (m_pcnt == PAUSE - 1) begin m_mode = 1; m_wleft = WAKE; end
           else m_pcnt = m_pcnt + 1;
        1: if (done) begin
             if (m_wleft == 1) m_mode = 2; else m_wleft = m_wleft - 1;
           end
        default: if (hit) begin m_mode = 1; m_wleft = WAKE; end
      endcase
      if (start) begin
        m_busy = 1; m_pos = 0;
      end else if (m_busy != 0) begin
        if (m_pos == CYCLEN - 1) m_busy = 0; else m_pos = m_pos + 1;
      end
    end
  end

  task automatic chk(input bit got, input bit exp, input string tag, input string what);
    vec_cnt++;
    if (got !== exp) begin
      err_cnt++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic chk_int(input int got, input int exp, input string tag, input string what);
    vec_cnt++;
    if (got != exp) begin
      err_cnt++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  // per-clock comparison against the model, plus RAS fall counting
  always @(negedge clk) begin
    chk(ras_n,     m_ras_n(),     "R3", "ras_n");
    chk(cas_n,     m_cas_n(),     "R3", "cas_n");
    chk(strobe_en, m_busy != 0,   "R4", "strobe_en");
    chk(we_n,      1'b1,          "R4", "we_n");
    chk(bus_req,   (m_busy != 0) || m_want(), "R5", "bus_req");
    chk(ready,     m_mode == 2,   "R2", "ready");
    if (!rst_n) begin
      fall_cnt = 0;
      prev_ras = 1'b1;
    end else begin
      if (prev_ras && !ras_n) fall_cnt++;
      prev_ras = ras_n;
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    err_cnt++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int n, f0;
    #1 rst_n = 1'b0;
    repeat (3) step();
    // R9 / R1: reset state
    chk(ready, 1'b0, "R9", "ready in reset");
    chk(bus_req, 1'b0, "R9", "bus_req in reset");
    chk(ras_n & cas_n, 1'b1, "R9", "strobes in reset");

    // R1: pause length
    bus_gnt = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (!bus_req && n < 200) begin step(); n++; end
    chk_int(n, PAUSE, "R1", "cycles until first request");

    // R2: wake burst length before ready
    n = 0;
    while (!ready && n < 300) begin step(); n++; end
    chk_int(fall_cnt, WAKE, "R2", "wake cycles before ready");

    // R5: normal pacing
    f0 = fall_cnt;
    repeat (INTV * 6) step();
    chk_int(fall_cnt - f0, 6, "R5", "refreshes over six intervals");

    // R6 / R8: long grant stall with host row activity
    bus_gnt = 1'b0;
    f0 = fall_cnt;
    for (int i = 0; i < 300; i++) begin
      host_ras_n = (i % 20 == 10) ? 1'b0 : 1'b1;
      step();
    end
    host_ras_n = 1'b1;
    chk(ready, 1'b1, "R8", "ready kept by host activity");
    chk_int(fall_cnt - f0, 0, "R4", "no cycles without grant");
    bus_gnt = 1'b1;
    f0 = fall_cnt;
    repeat (8 * (CYCLEN + 1)) step();
    chk_int(fall_cnt - f0, PMAX, "R6", "back-to-back drain after stall");

    // R7: idle timeout forces a fresh wake burst
    bus_gnt = 1'b0;
    repeat (IDLE + 40) step();
    chk(ready, 1'b0, "R7", "ready after idle timeout");
    f0 = fall_cnt;
    bus_gnt = 1'b1;
    n = 0;
    while (!ready && n < 300) begin step(); n++; end
    chk_int(fall_cnt - f0, WAKE, "R7", "wake cycles after idle");

    // R9: asynchronous reset in mid-run
    repeat (INTV) step();
    #2 rst_n = 1'b0;
    #1;
    chk(ready, 1'b0, "R9", "ready on async reset");
    chk(bus_req | strobe_en, 1'b0, "R9", "req/drive on async reset");
    repeat (2) step();
    rst_n = 1'b1;
    repeat (PAUSE + 10) step();

    report();
    $finish;
  end

endmodule